// File: doc/BRIEF.md
# Clock Frequency Info Register Block

This block is a read-only register window that describes the clocks of a design. Software reads a 32-bit register map in the core clock domain. The map holds three things. The first is a chain header: a fixed type word, a version word and a pointer to the next block, so the block can sit in a linked list of register blocks. The second is static clock facts: the number of channel clocks and the nominal periods of the reference and core clocks. The third is live frequency figures for the core clock and for each channel clock.

Each measured clock has its own rising-edge counter in its own domain. A gate timer in the reference clock domain flips a toggle once every `GATE_CYCLES` reference cycles. Each counter domain synchronises that toggle, latches its count when the toggle flips, and starts counting again. The latched count crosses back into the core domain through a toggle handshake. When the gate is one second of reference cycles, the figure read is the frequency in Hz.

Top module: `freq_info_block`

## Requirements
- R1: Word offset 0x00 reads the type value 0x0000C008, and offset 0x04 reads the version value 0x00000100.
- R2: Offset 0x08 reads the `NEXT_PTR` parameter.
- R3: Offset 0x0C reads `NUM_CHAN`, the number of channel clocks. The core and reference clocks are not counted.
- R4: Offset 0x10 reads the nominal reference period in ns, with the numerator in bits 31:16 and the denominator in bits 15:0. Offset 0x18 reads the nominal core period in the same layout.
- R5: Offset 0x1C reads the number of core clock rising edges counted in the most recent complete gate window of `GATE_CYCLES` reference cycles.
- R6: Offset 0x20 + 4n reads the edge count of channel clock n over the most recent complete gate window, for n from 0 to `NUM_CHAN`-1.
- R7: After reset, every measured register reads 0 until a full gate window has completed. The first gate toggle after reset only starts the counting.
- R8: Reads of offsets that are not mapped return 0. This covers 0x14, channel offsets at or above `NUM_CHAN`, and offsets past the map.
- R9: Write strobes have no effect on any register value.
- R10: `regRdValid` goes high for exactly the one cycle after a cycle with `regRdEn` high, and `regRdData` carries the value in that cycle. At other times `regRdValid` is low and `regRdData` is 0.
- R11: Asserting `rstN` clears all edge counters and latched values, so measured registers read 0 again.
- R12: Address bits 1:0 are ignored, so any byte address selects its containing word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| coreClk | input | 1 | Core clock; register interface domain and first measured clock |
| refClk | input | 1 | Reference timebase clock for the gate window |
| chanClk | input | NUM_CHAN | Channel clocks to be measured |
| rstN | input | 1 | Asynchronous active-low reset for all domains |
| regAddr | input | ADDR_W | Byte address of the access |
| regRdEn | input | 1 | Read strobe |
| regWrEn | input | 1 | Write strobe (ignored) |
| regWrData | input | 32 | Write data (ignored) |
| regRdData | output | 32 | Read data, valid with regRdValid |
| regRdValid | output | 1 | High one cycle after a read strobe |

## Verification
The bench builds the block with two channels and a gate of 100 reference cycles. Those values make a window 800 ns long, so several complete windows fit in a short run. It uses an 8 ns reference clock, the 5 ns core clock, and 10 ns and 4 ns channel clocks. Each clock starts at a different phase offset, so no two clocks ever share an edge time. As a result the exact counts 160, 80 and 200 are predictable, and reading offset 0x28 reaches the first unmapped channel slot. The two-window start-up delay after reset can be observed before the first value appears.

// File: rtl/freq_info_pkg.sv
package freq_info_pkg;
  localparam logic [31:0] BLK_TYPE = 32'h0000_C008;
  localparam logic [31:0] BLK_VER  = 32'h0000_0100;
  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TYPE,
    SEL_VER,
    SEL_NEXT,
    SEL_COUNT,
    SEL_REFPER,
    SEL_COREPER,
    SEL_MEAS
  } regSel_e;

  // Strobe bundle from control to datapath
  typedef struct packed {
    logic             rdStb;
    regSel_e          sel;
    logic [IDX_W-1:0] measIdx;   // 0 = core clock, n+1 = channel n
  } rdCmd_t;
endpackage

// File: rtl/freq_meas_lane.sv
module freq_meas_lane #(
  parameter int COUNT_W = 32
) (
  input  logic               measClk,
  input  logic               coreClk,
  input  logic               rstN,
  input  logic               gateTog,
  output logic [COUNT_W-1:0] capVal
);
  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

  // measured-clock domain
  logic [1:0]         gSync;
  logic               gPrev;
  logic               armed;
  logic               capTog;
  logic [COUNT_W-1:0] edgeCnt;
  logic [COUNT_W-1:0] heldCnt;
  logic               gTick;

  assign gTick = gSync[1] ^ gPrev;

  always_ff @(posedge measClk or negedge rstN) begin
    if (!rstN) begin
      gSync   <= '0;
      gPrev   <= 1'b0;
      armed   <= 1'b0;
      capTog  <= 1'b0;
      edgeCnt <= '0;
      heldCnt <= '0;
    end else begin
      gSync <= {gSync[0], gateTog};
      gPrev <= gSync[1];
      if (gTick) begin
        edgeCnt <= COUNT_W'(1);
        armed   <= 1'b1;
        if (armed) begin
          heldCnt <= edgeCnt;
          capTog  <= ~capTog;
        end
      end else if (edgeCnt != CNT_MAX) begin
        edgeCnt <= edgeCnt + COUNT_W'(1);
      end
    end
  end

  // core domain: pick up the held count once the handshake toggle arrives
  logic [1:0] cSync;
  logic       cPrev;
  logic       cTick;

  assign cTick = cSync[1] ^ cPrev;

  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) begin
      cSync  <= '0;
      cPrev  <= 1'b0;
      capVal <= '0;
    end else begin
      cSync <= {cSync[0], capTog};
      cPrev <= cSync[1];
      if (cTick) capVal <= heldCnt;
    end
  end

  // R5: once counting has started the counter never wraps to zero
  p_cnt_no_wrap_r5: assert property (@(posedge measClk) disable iff (!rstN)
    armed |-> edgeCnt != '0);

  // R7: the published value only moves on a handshake arrival
  p_cap_stable_r7: assert property (@(posedge coreClk) disable iff (!rstN)
    !cTick |=> $stable(capVal));
endmodule

// File: rtl/freq_info_ctrl.sv
module freq_info_ctrl
  import freq_info_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_CHAN    = 2,
  parameter int GATE_CYCLES = 250_000_000
) (
  input  logic              coreClk,
  input  logic              refClk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRdEn,
  output rdCmd_t            rdCmd,
  output logic              gateTog
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int CNT_W  = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_REF   = CNT_W'(GATE_CYCLES - 1);
  localparam logic [31:0]      MEAS_FIRST = 32'd7;
  localparam logic [31:0]      MEAS_LAST  = 32'd7 + 32'(NUM_CHAN);

  // read decode (core domain); byte offset bits are dropped
  logic [31:0] wordIdx;
  assign wordIdx = 32'(regAddr[ADDR_W-1:2]);

  always_comb begin
    rdCmd.rdStb   = regRdEn;
    rdCmd.sel     = SEL_NONE;
    rdCmd.measIdx = '0;
    case (wordIdx)
      32'd0: rdCmd.sel = SEL_TYPE;
      32'd1: rdCmd.sel = SEL_VER;
      32'd2: rdCmd.sel = SEL_NEXT;
      32'd3: rdCmd.sel = SEL_COUNT;
      32'd4: rdCmd.sel = SEL_REFPER;
      32'd6: rdCmd.sel = SEL_COREPER;
      default: begin
        if (wordIdx >= MEAS_FIRST && wordIdx <= MEAS_LAST) begin
          rdCmd.sel     = SEL_MEAS;
          rdCmd.measIdx = IDX_W'(wordIdx - MEAS_FIRST);
        end
      end
    endcase
  end

  // gate timer (reference domain)
  logic [CNT_W-1:0] refCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      refCnt  <= '0;
      gateTog <= 1'b0;
    end else if (refCnt == LAST_REF) begin
      refCnt  <= '0;
      gateTog <= ~gateTog;
    end else begin
      refCnt <= refCnt + CNT_W'(1);
    end
  end

  // R8: a measurement select never points past the last channel
  p_meas_idx_bound_r8: assert property (@(posedge coreClk) disable iff (!rstN)
    rdCmd.sel == SEL_MEAS |-> 32'(rdCmd.measIdx) <= 32'(NUM_CHAN));

  // R5: gate timer stays inside its window
  p_gate_bound_r5: assert property (@(posedge refClk) disable iff (!rstN)
    refCnt <= LAST_REF);

  // unused write path lives at top; WORD_W kept for width sanity
  initial begin
    if (WORD_W < 4) $error("ADDR_W too small for the register map");
  end
endmodule

// File: rtl/freq_info_dp.sv
module freq_info_dp
  import freq_info_pkg::*;
#(
  parameter int          NUM_CHAN     = 2,
  parameter int          COUNT_W      = 32,
  parameter logic [31:0] NEXT_PTR     = 32'h0,
  parameter logic [31:0] REF_PERIOD   = 32'h0004_0001,
  parameter logic [31:0] CORE_PERIOD  = 32'h0004_0001
) (
  input  logic                coreClk,
  input  logic [NUM_CHAN-1:0] chanClk,
  input  logic                rstN,
  input  logic                gateTog,
  input  rdCmd_t              rdCmd,
  output logic [31:0]         rdData,
  output logic                rdValid
);
  localparam int NUM_MEAS = NUM_CHAN + 1;

  logic [NUM_MEAS-1:0] measClk;
  logic [COUNT_W-1:0]  measVal [NUM_MEAS];

  assign measClk = {chanClk, coreClk};

  for (genvar i = 0; i < NUM_MEAS; i++) begin : g_lane
    freq_meas_lane #(.COUNT_W(COUNT_W)) u_lane (
      .measClk (measClk[i]),
      .coreClk (coreClk),
      .rstN    (rstN),
      .gateTog (gateTog),
      .capVal  (measVal[i])
    );
  end

  logic [31:0] nextData;

  always_comb begin
    nextData = '0;
    case (rdCmd.sel)
      SEL_TYPE:    nextData = BLK_TYPE;
      SEL_VER:     nextData = BLK_VER;
      SEL_NEXT:    nextData = NEXT_PTR;
      SEL_COUNT:   nextData = 32'(NUM_CHAN);
      SEL_REFPER:  nextData = REF_PERIOD;
      SEL_COREPER: nextData = CORE_PERIOD;
      SEL_MEAS: begin
        for (int k = 0; k < NUM_MEAS; k++) begin
          if (32'(rdCmd.measIdx) == 32'(k)) nextData = 32'(measVal[k]);
        end
      end
      default:     nextData = '0;
    endcase
  end

  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdCmd.rdStb;
      rdData  <= rdCmd.rdStb ? nextData : '0;
    end
  end

  // R10: every strobe yields valid data on the next cycle
  p_valid_follows_r10: assert property (@(posedge coreClk) disable iff (!rstN)
    rdCmd.rdStb |=> rdValid);

  // R10: no valid without a strobe the cycle before
  p_no_spurious_valid_r10: assert property (@(posedge coreClk) disable iff (!rstN)
    !rdCmd.rdStb |=> !rdValid);

  // R1: a type select returns the type word
  p_type_word_r1: assert property (@(posedge coreClk) disable iff (!rstN)
    (rdCmd.rdStb && rdCmd.sel == SEL_TYPE) |=> rdData == BLK_TYPE);
endmodule

// File: rtl/freq_info_block.sv
module freq_info_block
  import freq_info_pkg::*;
#(
  parameter int          NUM_CHAN      = 2,
  parameter int          ADDR_W        = 8,
  parameter int          COUNT_W       = 32,
  parameter int          GATE_CYCLES   = 250_000_000,
  parameter logic [31:0] NEXT_PTR      = 32'h0,
  parameter logic [15:0] REF_PER_NUM   = 16'd4,
  parameter logic [15:0] REF_PER_DEN   = 16'd1,
  parameter logic [15:0] CORE_PER_NUM  = 16'd4,
  parameter logic [15:0] CORE_PER_DEN  = 16'd1
) (
  input  logic                coreClk,
  input  logic                refClk,
  input  logic [NUM_CHAN-1:0] chanClk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regRdEn,
  input  logic                regWrEn,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  output logic                regRdValid
);
  rdCmd_t rdCmd;
  logic   gateTog;

  // all registers are read-only: the write port is accepted and dropped
  logic unusedWr;
  assign unusedWr = ^{regWrEn, regWrData};

  freq_info_ctrl #(
    .ADDR_W      (ADDR_W),
    .NUM_CHAN    (NUM_CHAN),
    .GATE_CYCLES (GATE_CYCLES)
  ) u_ctrl (
    .coreClk (coreClk),
    .refClk  (refClk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regRdEn (regRdEn),
    .rdCmd   (rdCmd),
    .gateTog (gateTog)
  );

  freq_info_dp #(
    .NUM_CHAN    (NUM_CHAN),
    .COUNT_W     (COUNT_W),
    .NEXT_PTR    (NEXT_PTR),
    .REF_PERIOD  ({REF_PER_NUM, REF_PER_DEN}),
    .CORE_PERIOD ({CORE_PER_NUM, CORE_PER_DEN})
  ) u_dp (
    .coreClk (coreClk),
    .chanClk (chanClk),
    .rstN    (rstN),
    .gateTog (gateTog),
    .rdCmd   (rdCmd),
    .rdData  (regRdData),
    .rdValid (regRdValid)
  );
endmodule

// File: tb/freq_info_block_test.sv
`timescale 1ns/100ps
module freq_info_block_test;
  localparam int NCH = 2;

  logic           coreClk = 1'b0;
  logic           refClk  = 1'b0;
  logic [NCH-1:0] chanClk = '0;
  logic           rstN    = 1'b0;
  logic [7:0]     regAddr = '0;
  logic           regRdEn = 1'b0;
  logic           regWrEn = 1'b0;
  logic [31:0]    regWrData = '0;
  logic [31:0]    regRdData;
  logic           regRdValid;

  int total = 0;
  int bad   = 0;

  freq_info_block #(
    .NUM_CHAN     (NCH),
    .ADDR_W       (8),
    .COUNT_W      (32),
    .GATE_CYCLES  (100),
    .NEXT_PTR     (32'h0001_2300),
    .REF_PER_NUM  (16'd8),
    .REF_PER_DEN  (16'd1),
    .CORE_PER_NUM (16'd15),
    .CORE_PER_DEN (16'd3)
  ) uut (
    .coreClk    (coreClk),
    .refClk     (refClk),
    .chanClk    (chanClk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regRdEn    (regRdEn),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .regRdValid (regRdValid)
  );

  // 200 MHz core; other clocks phase-shifted so no edges coincide
  initial forever #2.5 coreClk = ~coreClk;
  initial begin #1.3; forever #4 refClk = ~refClk; end
  initial begin #0.7; forever #5 chanClk[0] = ~chanClk[0]; end
  initial begin #0.4; forever #2 chanClk[1] = ~chanClk[1]; end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge coreClk);
    regAddr = a;
    regRdEn = 1'b1;
    @(negedge coreClk);
    regRdEn = 1'b0;
    d = regRdData;
    v = regRdValid;
  endtask

  task automatic readChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    readReg(a, d, v);
    chk({req, " valid"}, {31'b0, v}, 32'd1);
    chk(req, d, exp);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (4) @(negedge coreClk);
    rstN = 1'b1;
  endtask

  task automatic waitUntil(input realtime t);
    while ($realtime < t) @(negedge coreClk);
  endtask

  task automatic testResetState();
    @(negedge coreClk);
    chk("R10 reset valid", {31'b0, regRdValid}, 32'd0);
    chk("R10 reset data", regRdData, 32'd0);
  endtask

  task automatic testHeader();
    readChk("R1 type", 8'h00, 32'h0000_C008);
    readChk("R1 version", 8'h04, 32'h0000_0100);
    readChk("R2 next pointer", 8'h08, 32'h0001_2300);
    readChk("R3 channel count", 8'h0C, 32'd2);
    readChk("R4 ref period", 8'h10, 32'h0008_0001);
    readChk("R4 core period", 8'h18, 32'h000F_0003);
    readChk("R12 byte addr 0x03", 8'h03, 32'h0000_C008);
    readChk("R12 byte addr 0x06", 8'h06, 32'h0000_0100);
  endtask

  task automatic testUnmapped();
    readChk("R8 offset 0x14", 8'h14, 32'd0);
    readChk("R8 channel 2 slot", 8'h28, 32'd0);
    readChk("R8 offset 0xFC", 8'hFC, 32'd0);
  endtask

  task automatic testValidPulse();
    readChk("R10 single read", 8'h0C, 32'd2);
    @(negedge coreClk);
    chk("R10 valid drops", {31'b0, regRdValid}, 32'd0);
    chk("R10 data idle", regRdData, 32'd0);
  endtask

  task automatic testEarlyZero();
    // first gate toggle near 820 ns only arms the counters
    waitUntil(1100.0);
    readChk("R7 core before window", 8'h1C, 32'd0);
    readChk("R7 chan0 before window", 8'h20, 32'd0);
  endtask

  task automatic testMeasure(input string tag);
    readChk({"R5 core count ", tag}, 8'h1C, 32'd160);
    readChk({"R6 chan0 count ", tag}, 8'h20, 32'd80);
    readChk({"R6 chan1 count ", tag}, 8'h24, 32'd200);
  endtask

  task automatic testWrites();
    @(negedge coreClk);
    regWrEn = 1'b1; regAddr = 8'h0C; regWrData = 32'hFFFF_FFFF;
    @(negedge coreClk);
    regAddr = 8'h1C; regWrData = 32'h1234_5678;
    @(negedge coreClk);
    regAddr = 8'h00; regWrData = 32'h0;
    @(negedge coreClk);
    regWrEn = 1'b0;
    readChk("R9 count after write", 8'h0C, 32'd2);
    readChk("R9 core freq after write", 8'h1C, 32'd160);
    readChk("R9 type after write", 8'h00, 32'h0000_C008);
  endtask

  task automatic testResetClears();
    doReset();
    readChk("R11 core cleared", 8'h1C, 32'd0);
    readChk("R11 chan1 cleared", 8'h24, 32'd0);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    testResetState();
    testHeader();
    testUnmapped();
    testValidPulse();
    testEarlyZero();
    waitUntil(2000.0);
    testMeasure("window A");
    waitUntil(2900.0);
    testMeasure("window B");
    testWrites();
    testResetClears();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule